// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles where a 64-bit, two-operand instruction stream goes after a jump-class instruction. It takes the decoded opcode byte, the two register operands, the 32-bit immediate, the 16-bit signed offset and the current program counter. It then reports the next program counter and one outcome: a taken branch, a request to call an external function, a request to end the program, or an illegal opcode. A failed condition has no second target. Execution simply falls through to the following slot.

The opcode byte carries three fields. Bits [2:0] give the class: 5 is the 64-bit comparing class and 6 is the class that compares only the lower 32 bits. Bit 3 selects the second operand. Bits [7:4] give the operation. Program counters count 8-byte instruction slots, and a program holds at most `PROG_SLOTS` (4096) slots. Results appear one clock after an input marked valid.

Top module: `br_resolve`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock. While `out_valid` is 0, `taken`, `call_req`, `exit_req`, `illegal` and `range_fault` are all 0. All of these are 0 during reset.
- R2: Opcode bit 3 (0x08) selects the second operand. When set, the source register is used. When clear, the immediate is used, and in class 5 the immediate is sign-extended to 64 bits before the comparison.
- R3: Class 6 (opcode bits [2:0] = 6) compares only bits [31:0] of both operands. In signed relations, bit 31 is the sign bit.
- R4: Operation 0x1 (JEQ) branches when the operands are equal. Operation 0x5 (JNE) branches when they differ. Operation 0x4 (JSET) branches when the bitwise AND of the operands is nonzero.
- R5: The following operations compare unsigned: 0x2 (JGT, greater), 0x3 (JGE, greater or equal), 0xa (JLT, less) and 0xb (JLE, less or equal).
- R6: The following operations compare signed, in two's complement: 0x6 (JSGT, greater), 0x7 (JSGE, greater or equal), 0xc (JSLT, less) and 0xd (JSLE, less or equal).
- R7: A taken branch sets `taken` and drives `next_pc` to pc + 1 + sign-extended offset. A failed condition leaves `taken` at 0 and drives `next_pc` to pc + 1, modulo 2^PC_W.
- R8: Operation 0x0 (JA) in class 5 branches unconditionally.
- R9: Operation 0x8 (CALL) in class 5 sets `call_req`. In that case `call_id` equals the immediate, `taken` is 0 and `next_pc` is pc + 1.
- R10: Operation 0x9 (EXIT) in class 5 sets `exit_req`, with `taken` at 0 and `next_pc` at pc + 1.
- R11: `illegal` is raised, with no other outcome and `next_pc` at pc + 1, in three cases: a class other than 5 or 6, operation 0xe or 0xf, or operation 0x0, 0x8 or 0x9 in class 6.
- R12: When a taken target is below 0 or at or above `PROG_SLOTS`, `range_fault` is raised together with `taken`. In that case `next_pc` holds the target modulo 2^PC_W.
- R13: At most one of `taken`, `call_req`, `exit_req` and `illegal` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs carry an instruction to resolve |
| opcode | input | 8 | Opcode byte: operation, operand select, class |
| dst_val | input | 64 | Destination register value (first operand) |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate; also the function identifier for calls |
| offset | input | 16 | Signed branch displacement in slots |
| pc | input | 12 | Current slot index |
| out_valid | output | 1 | Registered results are valid |
| next_pc | output | 12 | Resolved next slot index |
| taken | output | 1 | Branch taken |
| call_req | output | 1 | External function call requested |
| call_id | output | 32 | Function identifier for the call |
| exit_req | output | 1 | Program end requested |
| illegal | output | 1 | Opcode not legal in the jump classes |
| range_fault | output | 1 | Taken target outside the program |

## Verification
A taken branch and a range fault can fall in the same cycle. This happens whenever a condition holds and the offset carries the target past either end of the program. The sweep pairs every operation and class with offsets of 0x7FFF, 0x8000, 4000 and -512 at many program counters. It judges each result against an arithmetic model that computes the target as a signed integer and requires `taken` and `range_fault` together, with the wrapped target on `next_pc`. The sweep also drives illegal encodings next to legal ones with the same operands. This shows that a condition which would hold raises no branch once the encoding is rejected.

// File: rtl/br_pkg.sv
// Package br_pkg
// Shared encodings and the decoded-instruction record for the branch
// resolution unit. Assumes the opcode layout: [7:4] operation,
// [3] operand select, [2:0] class.
package br_pkg;

    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    localparam logic [3:0] OPF_ALWAYS = 4'h0;
    localparam logic [3:0] OPF_EQ     = 4'h1;
    localparam logic [3:0] OPF_GT     = 4'h2;
    localparam logic [3:0] OPF_GE     = 4'h3;
    localparam logic [3:0] OPF_SET    = 4'h4;
    localparam logic [3:0] OPF_NE     = 4'h5;
    localparam logic [3:0] OPF_SGT    = 4'h6;
    localparam logic [3:0] OPF_SGE    = 4'h7;
    localparam logic [3:0] OPF_CALL   = 4'h8;
    localparam logic [3:0] OPF_EXIT   = 4'h9;
    localparam logic [3:0] OPF_LT     = 4'ha;
    localparam logic [3:0] OPF_LE     = 4'hb;
    localparam logic [3:0] OPF_SLT    = 4'hc;
    localparam logic [3:0] OPF_SLE    = 4'hd;

    typedef enum logic [3:0] {
        CND_EQ, CND_NE, CND_SET,
        CND_UGT, CND_UGE, CND_ULT, CND_ULE,
        CND_SGT, CND_SGE, CND_SLT, CND_SLE,
        CND_NONE
    } cond_e;

    typedef struct packed {
        logic  is_cond;
        logic  is_ja;
        logic  is_call;
        logic  is_exit;
        logic  illegal;
        logic  narrow;
        logic  use_reg;
        cond_e cond;
    } dec_t;

endpackage

// File: rtl/br_decode.sv
// Module br_decode
// Splits an opcode byte into a decoded record. Purely combinational.
// Assumes only classes CLS_WIDE and CLS_NARROW are legal here; any
// other class, or an unconditional/call/exit form in the narrow class,
// is marked illegal with every outcome flag cleared.
module br_decode
    import br_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);

    logic [2:0] cls;
    logic [3:0] opf;
    logic       wide;
    logic       narrow;

    assign cls    = opcode[2:0];
    assign opf    = opcode[7:4];
    assign wide   = (cls == CLS_WIDE);
    assign narrow = (cls == CLS_NARROW);

    // Map operation field and class onto the decoded record.
    always_comb begin
        dec         = '0;
        dec.cond    = CND_NONE;
        dec.narrow  = narrow;
        dec.use_reg = opcode[3];
        if (!(wide || narrow)) begin
            dec.illegal = 1'b1;
        end else begin
            unique case (opf)
                OPF_ALWAYS: begin dec.is_ja   = wide; dec.illegal = narrow; end
                OPF_CALL:   begin dec.is_call = wide; dec.illegal = narrow; end
                OPF_EXIT:   begin dec.is_exit = wide; dec.illegal = narrow; end
                OPF_EQ:     begin dec.is_cond = 1'b1; dec.cond = CND_EQ;  end
                OPF_NE:     begin dec.is_cond = 1'b1; dec.cond = CND_NE;  end
                OPF_SET:    begin dec.is_cond = 1'b1; dec.cond = CND_SET; end
                OPF_GT:     begin dec.is_cond = 1'b1; dec.cond = CND_UGT; end
                OPF_GE:     begin dec.is_cond = 1'b1; dec.cond = CND_UGE; end
                OPF_LT:     begin dec.is_cond = 1'b1; dec.cond = CND_ULT; end
                OPF_LE:     begin dec.is_cond = 1'b1; dec.cond = CND_ULE; end
                OPF_SGT:    begin dec.is_cond = 1'b1; dec.cond = CND_SGT; end
                OPF_SGE:    begin dec.is_cond = 1'b1; dec.cond = CND_SGE; end
                OPF_SLT:    begin dec.is_cond = 1'b1; dec.cond = CND_SLT; end
                OPF_SLE:    begin dec.is_cond = 1'b1; dec.cond = CND_SLE; end
                default:    dec.illegal = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/br_cmp.sv
// Module br_cmp
// Produces the primitive relations between two W-bit operands:
// equality, unsigned less-than, signed less-than, and any common set bit.
// All other relations are derived from these by the caller.
module br_cmp #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq,
    output logic         ult,
    output logic         slt,
    output logic         anyset
);

    // Evaluate the four primitive relations.
    always_comb begin
        eq     = (a == b);
        ult    = (a < b);
        slt    = ($signed(a) < $signed(b));
        anyset = |(a & b);
    end

endmodule

// File: rtl/br_target.sv
// Module br_target
// Computes the taken target pc + 1 + sign-extended offset in a signed
// width large enough to hold no overflow, flags targets outside
// [0, SLOTS-1], and computes the fall-through slot modulo 2^PC_W.
module br_target #(
    parameter int SLOTS = 4096,
    parameter int PC_W  = 12,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    output logic [PC_W-1:0]  target,
    output logic             out_of_range,
    output logic [PC_W-1:0]  fall_pc
);

    localparam int TW = ((PC_W > OFF_W) ? PC_W : OFF_W) + 2;

    logic signed [TW-1:0] pc_s;
    logic signed [TW-1:0] off_s;
    logic signed [TW-1:0] sum_s;

    // Widen operands and form the full signed target.
    always_comb begin
        pc_s  = $signed({{(TW-PC_W){1'b0}}, pc});
        off_s = $signed({{(TW-OFF_W){offset[OFF_W-1]}}, offset});
        sum_s = pc_s + off_s + $signed(TW'(1));
    end

    // Range check against the program size and truncate for output.
    always_comb begin
        out_of_range = (sum_s < $signed(TW'(0))) || (sum_s >= $signed(TW'(SLOTS)));
        target       = sum_s[PC_W-1:0];
        fall_pc      = pc + {{(PC_W-1){1'b0}}, 1'b1};
    end

endmodule

// File: rtl/br_resolve.sv
// Module br_resolve (top)
// Resolves the next slot for one jump-class instruction per valid cycle.
// Operand selection, wide and narrow comparison, target arithmetic and
// decode run in parallel; one register stage holds the result. Assumes
// the caller holds no expectation on outputs while out_valid is low
// except that the outcome flags read zero.
module br_resolve #(
    parameter int DATA_W     = 64,
    parameter int HALF_W     = 32,
    parameter int IMM_W      = 32,
    parameter int OFF_W      = 16,
    parameter int PROG_SLOTS = 4096,
    localparam int PC_W      = $clog2(PROG_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic [OFF_W-1:0]  offset,
    input  logic [PC_W-1:0]   pc,
    output logic              out_valid,
    output logic [PC_W-1:0]   next_pc,
    output logic              taken,
    output logic              call_req,
    output logic [IMM_W-1:0]  call_id,
    output logic              exit_req,
    output logic              illegal,
    output logic              range_fault
);

    import br_pkg::*;

    dec_t              dec;
    logic [DATA_W-1:0] opnd_b;
    logic              w_eq, w_ult, w_slt, w_any;
    logic              n_eq, n_ult, n_slt, n_any;
    logic              c_eq, c_ult, c_slt, c_any;
    logic              hit;
    logic              take_c;
    logic [PC_W-1:0]   tgt_pc;
    logic [PC_W-1:0]   fall_pc;
    logic              oor;

    br_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    // Pick the second operand: register or sign-extended immediate.
    always_comb begin
        opnd_b = dec.use_reg ? src_val
                             : {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    end

    br_cmp #(.W(DATA_W)) u_cmp_wide (
        .a      (dst_val),
        .b      (opnd_b),
        .eq     (w_eq),
        .ult    (w_ult),
        .slt    (w_slt),
        .anyset (w_any)
    );

    br_cmp #(.W(HALF_W)) u_cmp_narrow (
        .a      (dst_val[HALF_W-1:0]),
        .b      (opnd_b[HALF_W-1:0]),
        .eq     (n_eq),
        .ult    (n_ult),
        .slt    (n_slt),
        .anyset (n_any)
    );

    br_target #(.SLOTS(PROG_SLOTS), .PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc           (pc),
        .offset       (offset),
        .target       (tgt_pc),
        .out_of_range (oor),
        .fall_pc      (fall_pc)
    );

    // Choose the relation set matching the operand width of the class.
    always_comb begin
        c_eq  = dec.narrow ? n_eq  : w_eq;
        c_ult = dec.narrow ? n_ult : w_ult;
        c_slt = dec.narrow ? n_slt : w_slt;
        c_any = dec.narrow ? n_any : w_any;
    end

    // Reduce the selected relations to the requested condition.
    always_comb begin
        unique case (dec.cond)
            CND_EQ:  hit = c_eq;
            CND_NE:  hit = !c_eq;
            CND_SET: hit = c_any;
            CND_UGT: hit = !c_ult && !c_eq;
            CND_UGE: hit = !c_ult;
            CND_ULT: hit = c_ult;
            CND_ULE: hit = c_ult || c_eq;
            CND_SGT: hit = !c_slt && !c_eq;
            CND_SGE: hit = !c_slt;
            CND_SLT: hit = c_slt;
            CND_SLE: hit = c_slt || c_eq;
            default: hit = 1'b0;
        endcase
        take_c = dec.is_ja || (dec.is_cond && hit);
    end

    // Register the resolved outcome; flags clear on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            next_pc     <= '0;
            taken       <= 1'b0;
            call_req    <= 1'b0;
            call_id     <= '0;
            exit_req    <= 1'b0;
            illegal     <= 1'b0;
            range_fault <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                next_pc     <= take_c ? tgt_pc : fall_pc;
                taken       <= take_c;
                call_req    <= dec.is_call;
                call_id     <= imm;
                exit_req    <= dec.is_exit;
                illegal     <= dec.illegal;
                range_fault <= take_c && oor;
            end else begin
                taken       <= 1'b0;
                call_req    <= 1'b0;
                exit_req    <= 1'b0;
                illegal     <= 1'b0;
                range_fault <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/br_resolve_chk.sv
// Module br_resolve_chk
// Temporal checks on the ports of br_resolve, attached by bind.
module br_resolve_chk #(
    parameter int PC_W  = 12,
    parameter int IMM_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PC_W-1:0]  pc,
    input logic [IMM_W-1:0] imm,
    input logic             out_valid,
    input logic [PC_W-1:0]  next_pc,
    input logic             taken,
    input logic             call_req,
    input logic [IMM_W-1:0] call_id,
    input logic             exit_req,
    input logic             illegal,
    input logic             range_fault
);

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(taken || call_req || exit_req || illegal || range_fault));

    // R13
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken, call_req, exit_req, illegal}));

    // R12
    fault_with_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_fault |-> taken);

    // R7
    fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> (next_pc == PC_W'($past(pc) + 1'b1)));

    // R9
    call_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (call_id == $past(imm)));

endmodule

bind br_resolve br_resolve_chk #(.PC_W(PC_W), .IMM_W(IMM_W)) chk_i (.*);

// File: tb/br_resolve_tb.sv
// Bench br_resolve_tb_top
// Sweeps every opcode byte of the form {operation, select, class} over a
// grid of operand pairs, offsets and slot indices, and compares each
// registered result with an arithmetic model.
module br_resolve_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm = '0;
    logic [15:0] offset = '0;
    logic [11:0] pc = '0;
    logic        out_valid;
    logic [11:0] next_pc;
    logic        taken;
    logic        call_req;
    logic [31:0] call_id;
    logic        exit_req;
    logic        illegal;
    logic        range_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    br_resolve dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .opcode (opcode),
        .dst_val (dst_val), .src_val (src_val), .imm (imm), .offset (offset),
        .pc (pc), .out_valid (out_valid), .next_pc (next_pc), .taken (taken),
        .call_req (call_req), .call_id (call_id), .exit_req (exit_req),
        .illegal (illegal), .range_fault (range_fault)
    );

    function automatic logic [63:0] val_of(input int k);
        case (k)
            0: return 64'h0;
            1: return 64'h1;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h7FFF_FFFF_FFFF_FFFF;
            5: return 64'h0000_0000_8000_0000;
            6: return 64'h1234_5678_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_0000_0001;
        endcase
    endfunction

    function automatic logic [15:0] off_of(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'd200;
            4: return 16'hFE00;
            5: return 16'h7FFF;
            6: return 16'h8000;
            default: return 16'd4000;
        endcase
    endfunction

    // Arithmetic model of the requirements.
    function automatic void model(input logic [7:0] op, input logic [63:0] d,
                                  input logic [63:0] s, input logic [31:0] im,
                                  input logic [15:0] of, input logic [11:0] p,
                                  output logic e_tk, output logic e_cl,
                                  output logic e_ex, output logic e_il,
                                  output logic e_ft, output logic [11:0] e_np);
        logic [2:0]  cls  = op[2:0];
        logic [3:0]  code = op[7:4];
        logic        w64  = (cls == 3'd5);
        logic        w32  = (cls == 3'd6);
        logic [63:0] bb   = op[3] ? s : {{32{im[31]}}, im};
        logic [63:0] ua, ub, sa, sb;
        logic        eq, ult, slt, anyb, tk;
        int          tgt;
        if (w32) begin
            ua = {32'b0, d[31:0]};             ub = {32'b0, bb[31:0]};
            sa = {{32{d[31]}}, d[31:0]};       sb = {{32{bb[31]}}, bb[31:0]};
        end else begin
            ua = d; ub = bb; sa = d; sb = bb;
        end
        eq   = (ua == ub);
        ult  = (ua < ub);
        slt  = ($signed(sa) < $signed(sb));
        anyb = ((ua & ub) != 64'h0);
        e_il = !(w64 || w32) || (code >= 4'he) ||
               (w32 && (code == 4'h0 || code == 4'h8 || code == 4'h9));
        e_cl = !e_il && code == 4'h8;
        e_ex = !e_il && code == 4'h9;
        case (code)
            4'h0: tk = 1'b1;
            4'h1: tk = eq;
            4'h2: tk = !ult && !eq;
            4'h3: tk = !ult;
            4'h4: tk = anyb;
            4'h5: tk = !eq;
            4'h6: tk = !slt && !eq;
            4'h7: tk = !slt;
            4'ha: tk = ult;
            4'hb: tk = ult || eq;
            4'hc: tk = slt;
            4'hd: tk = slt || eq;
            default: tk = 1'b0;
        endcase
        e_tk = tk && !e_il;
        tgt  = int'(p) + 1 + int'(signed'(of));
        e_ft = e_tk && (tgt < 0 || tgt > 4095);
        e_np = e_tk ? tgt[11:0] : p + 12'd1;
    endfunction

    function automatic string tag_of(input logic [7:0] op, input logic il);
        string t;
        if (il)                                       t = "R11";
        else if (op[7:4] == 4'h0)                     t = "R8";
        else if (op[7:4] == 4'h8)                     t = "R9";
        else if (op[7:4] == 4'h9)                     t = "R10";
        else if (op[7:4] inside {4'h1, 4'h4, 4'h5})   t = "R4";
        else if (op[7:4] inside {4'h2, 4'h3, 4'ha, 4'hb}) t = "R5";
        else                                          t = "R6";
        t = {t, (op[2:0] == 3'd6) ? " R3" : " R2", " R7 R12"};
        return t;
    endfunction

    // Drive one instruction, wait one clock, compare the registered result.
    task automatic apply(input logic [7:0] op, input logic [63:0] d,
                         input logic [63:0] s, input logic [31:0] im,
                         input logic [15:0] of, input logic [11:0] p);
        logic e_tk, e_cl, e_ex, e_il, e_ft;
        logic [11:0] e_np;
        logic [16:0] act, exp;
        model(op, d, s, im, of, p, e_tk, e_cl, e_ex, e_il, e_ft, e_np);
        in_valid = 1'b1; opcode = op; dst_val = d; src_val = s;
        imm = im; offset = of; pc = p;
        @(negedge clk);
        act = {out_valid, taken, call_req, exit_req, illegal, next_pc};
        exp = {1'b1, e_tk, e_cl, e_ex, e_il, e_np};
        checks++;
        if (act !== exp || range_fault !== e_ft || (e_cl && call_id !== im)) begin
            fails++;
            $display("FAIL %s op=%h act={v,tk,cl,ex,il,np}=%h ft=%b id=%h exp=%h ft=%b id=%h",
                     tag_of(op, e_il), op, act, range_fault, call_id, exp, e_ft, im);
        end
        // R13: at most one outcome flag
        checks++;
        if ($countones({taken, call_req, exit_req, illegal}) > 1) begin
            fails++;
            $display("FAIL R13 flags=%b exp at most one set",
                     {taken, call_req, exit_req, illegal});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if ({out_valid, taken, call_req, exit_req, illegal, range_fault, next_pc} !== '0) begin
            fails++;
            $display("FAIL R1 reset outputs act=%b exp=0",
                     {out_valid, taken, call_req, exit_req, illegal, range_fault});
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int code = 0; code < 16; code++) begin
            for (int cls = 0; cls < 8; cls++) begin
                for (int x = 0; x < 2; x++) begin
                    for (int i = 0; i < 8; i++) begin
                        for (int j = 0; j < 8; j++) begin
                            apply({code[3:0], x[0], cls[2:0]}, val_of(i), val_of(j),
                                  val_of(j)[31:0], off_of((i + j + code) % 8),
                                  12'(i * 517 + j * 33 + code * 7));
                        end
                    end
                end
            end
        end
        // R1: idle cycle after a taken branch must read quiet
        apply(8'h05, 64'h0, 64'h0, 32'h0, 16'h0, 12'd10);
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if ({out_valid, taken, call_req, exit_req, illegal, range_fault} !== 6'b0) begin
            fails++;
            $display("FAIL R1 idle outputs act=%b exp=000000",
                     {out_valid, taken, call_req, exit_req, illegal, range_fault});
        end
        // R7 R12: edge targets (last slot, one past end, one before start)
        apply(8'h05, 64'h0, 64'h0, 32'h0, 16'h0000, 12'd4094);
        apply(8'h05, 64'h0, 64'h0, 32'h0, 16'h0000, 12'd4095);
        apply(8'h05, 64'h0, 64'h0, 32'h0, 16'hFFFE, 12'd0);
        apply(8'h05, 64'h0, 64'h0, 32'h0, 16'hFFFF, 12'd0);
        apply(8'h15, 64'h5, 64'h6, 32'h0, 16'h0003, 12'd4095);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule